// File: doc/BRIEF.md
# Byte-to-Word Storage Bus Bridge

This bridge sits between a processor bus that moves one byte per access and a storage device whose register file moves sixteen bits per transfer. The processor addresses each device register as a byte pair. The low address bit selects the byte lane. An access to the even byte and an access to the odd byte that follows it together make one device transfer. Two byte-wide holding registers carry the half of the word that is not moved in the cycle where the device is strobed.

The trigger point is different for the two directions. A read starts the device transfer on the even byte. The bridge returns the low half of the word straight away and keeps the high half, which the odd read then collects without touching the device. A write does nothing on the device at the even byte and only stores that byte. The odd write then strobes the device with the processor byte on the upper lane and the stored byte on the lower lane. The upper register address bits pass straight through to the device.

Top module: `bb_bridge`

## Requirements
- R1: After reset both holding registers read as 0x00. An odd read returns 0x00, and a lone odd write places 0x00 on device data bits [7:0].
- R2: A read at an even address (chip select high, read high, write low, addrLo=0) raises devRdStb in the same cycle and returns devRdData[7:0] on rdData in that cycle.
- R3: An even read loads devRdData[15:8] into the read holding register at the clock edge that ends the access.
- R4: A read at an odd address (addrLo=1) returns the read holding register on rdData and keeps devRdStb and devWrStb low.
- R5: A write at an even address stores wrData into the write holding register at the clock edge and keeps both device strobes low.
- R6: A write at an odd address raises devWrStb and drives devWrData with wrData on bits [15:8] and the write holding register on bits [7:0].
- R7: A holding register changes only on its own loading access: an even read for the read holder, an even write for the write holder. Odd accesses, deselected cycles and accesses in the other direction leave it unchanged.
- R8: devWrOe equals devWrStb, and devWrData is zero whenever devWrOe is low.
- R9: rdData is zero in any cycle that is not a read access, including every cycle with chip select low.
- R10: A cycle with read and write asserted together is no access. No strobe rises, rdData is zero and neither holding register changes.
- R11: devAddr always equals regAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select from the processor |
| rdEn | input | 1 | Processor read strobe |
| wrEn | input | 1 | Processor write strobe |
| addrLo | input | 1 | Byte lane select: 0 even, 1 odd |
| regAddr | input | REG_ADDR_W | Device register address |
| wrData | input | BYTE_W | Processor write byte |
| rdData | output | BYTE_W | Processor read byte |
| devAddr | output | REG_ADDR_W | Register address to the device |
| devRdStb | output | 1 | Device read strobe |
| devWrStb | output | 1 | Device write strobe |
| devWrOe | output | 1 | Output enable for devWrData |
| devWrData | output | 2*BYTE_W | Word driven to the device |
| devRdData | input | 2*BYTE_W | Word returned by the device |

## Verification
A wrong holding register does not show when it goes wrong. A bad read holder appears only at the next odd read, as a wrong byte on rdData. A bad write holder appears only at the next odd write, on devWrData[7:0]. The bench therefore follows loads with reads, writes and deselected cycles before it observes the holder, so that an unwanted update shows at the first odd access afterward. Strobe and data-lane faults are combinational and show in the cycle of the access itself.

// File: rtl/bb_pkg.sv
package bb_pkg;

  // Decoded access kinds passed from control to datapath
  typedef struct packed {
    logic rdEven;
    logic rdOdd;
    logic wrEven;
    logic wrOdd;
  } bbStrobes_t;

endpackage

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic       cs,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic       addrLo,
  output bbStrobes_t stb,
  output logic       devRdStb,
  output logic       devWrStb
);

  logic access;
  logic isRead;
  logic isWrite;

  // read and write together is treated as no access at all
  assign access  = cs & (rdEn ^ wrEn);
  assign isRead  = access & rdEn;
  assign isWrite = access & wrEn;

  always_comb begin
    stb.rdEven = isRead  & ~addrLo;
    stb.rdOdd  = isRead  &  addrLo;
    stb.wrEven = isWrite & ~addrLo;
    stb.wrOdd  = isWrite &  addrLo;
  end

  // device is touched only on the even read and the odd write
  assign devRdStb = isRead  & ~addrLo;
  assign devWrStb = isWrite &  addrLo;

endmodule

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bbStrobes_t            stb,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic [2*BYTE_W-1:0]   devRdData,
  output logic [BYTE_W-1:0]     rdData,
  output logic [2*BYTE_W-1:0]   devWrData,
  output logic                  devWrOe
);

  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] rdHold;
  logic [BYTE_W-1:0] wrHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdHold <= '0;
      wrHold <= '0;
    end else begin
      if (stb.rdEven) rdHold <= devRdData[WORD_W-1:BYTE_W];
      if (stb.wrEven) wrHold <= wrData;
    end
  end

  always_comb begin
    if (stb.rdEven)     rdData = devRdData[BYTE_W-1:0];
    else if (stb.rdOdd) rdData = rdHold;
    else                rdData = '0;
  end

  assign devWrOe   = stb.wrOdd;
  assign devWrData = stb.wrOdd ? {wrData, wrHold} : '0;

endmodule

// File: rtl/bb_bridge.sv
module bb_bridge
  import bb_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int REG_ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cs,
  input  logic                    rdEn,
  input  logic                    wrEn,
  input  logic                    addrLo,
  input  logic [REG_ADDR_W-1:0]   regAddr,
  input  logic [BYTE_W-1:0]       wrData,
  output logic [BYTE_W-1:0]       rdData,
  output logic [REG_ADDR_W-1:0]   devAddr,
  output logic                    devRdStb,
  output logic                    devWrStb,
  output logic                    devWrOe,
  output logic [2*BYTE_W-1:0]     devWrData,
  input  logic [2*BYTE_W-1:0]     devRdData
);

  bbStrobes_t stb;

  bb_ctrl u_ctrl (
    .cs       (cs),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .addrLo   (addrLo),
    .stb      (stb),
    .devRdStb (devRdStb),
    .devWrStb (devWrStb)
  );

  bb_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .devRdData (devRdData),
    .rdData    (rdData),
    .devWrData (devWrData),
    .devWrOe   (devWrOe)
  );

  assign devAddr = regAddr;

endmodule

// File: rtl/bb_bridge_chk.sv
module bb_bridge_chk #(
  parameter int BYTE_W     = 8,
  parameter int REG_ADDR_W = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cs,
  input logic                  rdEn,
  input logic                  wrEn,
  input logic                  addrLo,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [BYTE_W-1:0]     wrData,
  input logic [BYTE_W-1:0]     rdData,
  input logic [REG_ADDR_W-1:0] devAddr,
  input logic                  devRdStb,
  input logic                  devWrStb,
  input logic                  devWrOe,
  input logic [2*BYTE_W-1:0]   devWrData,
  input logic [2*BYTE_W-1:0]   devRdData
);

  logic armed;
  logic evRd, odRd, evWr, odWr;

  assign evRd = cs & rdEn & ~wrEn & ~addrLo;
  assign odRd = cs & rdEn & ~wrEn &  addrLo;
  assign evWr = cs & wrEn & ~rdEn & ~addrLo;
  assign odWr = cs & wrEn & ~rdEn &  addrLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R2
  even_read_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    evRd |-> (devRdStb && rdData == devRdData[BYTE_W-1:0]));

  // R3
  read_hold_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(evRd) && odRd) |-> rdData == $past(devRdData[2*BYTE_W-1:BYTE_W]));

  // R4
  odd_read_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    odRd |-> (!devRdStb && !devWrStb));

  // R5
  even_write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    evWr |-> (!devRdStb && !devWrStb));

  // R6
  write_pair_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(evWr) && odWr) |-> (devWrStb && devWrData == {wrData, $past(wrData)}));

  // R8
  oe_matches_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    devWrOe == devWrStb);

  // R8
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !devWrOe |-> devWrData == '0);

  // R9
  deselect_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cs |-> (rdData == '0 && !devRdStb && !devWrStb));

  // R10
  clash_no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && wrEn) |-> (!devRdStb && !devWrStb && rdData == '0));

  // R11
  addr_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    devAddr == regAddr);

endmodule

bind bb_bridge bb_bridge_chk #(.BYTE_W(BYTE_W), .REG_ADDR_W(REG_ADDR_W)) u_chk (.*);

// File: tb/bb_bridge_tb.sv
module bb_bridge_tb;

  localparam int BW = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cs = 1'b0, rdEn = 1'b0, wrEn = 1'b0, addrLo = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [BW-1:0] wrData = '0;
  logic [BW-1:0] rdData;
  logic [AW-1:0] devAddr;
  logic          devRdStb, devWrStb, devWrOe;
  logic [2*BW-1:0] devWrData;
  logic [2*BW-1:0] devRdData = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [BW-1:0] mRd = '0;
  logic [BW-1:0] mWr = '0;

  always #5 clk = ~clk;

  bb_bridge #(.BYTE_W(BW), .REG_ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .cs(cs), .rdEn(rdEn), .wrEn(wrEn), .addrLo(addrLo),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .devAddr(devAddr),
    .devRdStb(devRdStb), .devWrStb(devWrStb), .devWrOe(devWrOe),
    .devWrData(devWrData), .devRdData(devRdData)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string pickTag(bit c, bit r, bit w, bit a);
    if (c && r && w) return "R10";
    if (!(c && (r ^ w))) return "R9";
    if (r) return a ? "R4" : "R2";
    return a ? "R6" : "R5";
  endfunction

  // One processor cycle: drive after negedge, check before posedge, model the edge
  task automatic cyc(bit c, bit r, bit w, bit a, logic [AW-1:0] ra,
                     logic [BW-1:0] wd, logic [2*BW-1:0] dr, string ovr);
    bit acc, er, orr, ew, ow;
    string tag;
    @(negedge clk);
    cs = c; rdEn = r; wrEn = w; addrLo = a; regAddr = ra; wrData = wd; devRdData = dr;
    #2;
    acc = c && (r != w);
    er = acc && r && !a;  orr = acc && r && a;
    ew = acc && w && !a;  ow = acc && w && a;
    tag = (ovr != "") ? ovr : pickTag(c, r, w, a);
    chk(tag, "devRdStb", 32'(devRdStb), 32'(er));
    chk(tag, "devWrStb", 32'(devWrStb), 32'(ow));
    chk("R8", "devWrOe", 32'(devWrOe), 32'(ow));
    chk(tag, "devWrData", 32'(devWrData), ow ? 32'({wd, mWr}) : 32'h0);
    chk(tag, "rdData", 32'(rdData), er ? 32'(dr[BW-1:0]) : (orr ? 32'(mRd) : 32'h0));
    chk("R11", "devAddr", 32'(devAddr), 32'(ra));
    if (er) mRd = dr[2*BW-1:BW];
    if (ew) mWr = wd;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_B1D6));
    repeat (3) @(posedge clk);
    #2;
    // R1: idle outputs in reset
    chk("R1", "rdData in reset", 32'(rdData), 0);
    chk("R1", "strobes in reset", 32'({devRdStb, devWrStb, devWrOe}), 0);
    @(negedge clk); rstN = 1'b1;

    // R1: holders come out of reset at zero
    cyc(1, 1, 0, 1, 3'd2, 8'h00, 16'hFFFF, "R1");
    cyc(1, 0, 1, 1, 3'd2, 8'hA5, 16'h0000, "R1");

    // R3: even read then odd read reassembles the word
    cyc(1, 1, 0, 0, 3'd0, 8'h00, 16'hBEEF, "R2");
    cyc(1, 1, 0, 1, 3'd0, 8'h00, 16'h0000, "R3");
    // R2: lone even read of a byte register
    cyc(1, 1, 0, 0, 3'd7, 8'h00, 16'h1234, "R2");
    // R7: deselected, write-side and odd cycles keep the read holder
    cyc(0, 1, 0, 0, 3'd1, 8'h00, 16'hCC55, "R7");
    cyc(1, 0, 1, 0, 3'd1, 8'h3C, 16'hDD66, "R7");
    cyc(1, 1, 0, 1, 3'd1, 8'h00, 16'hEE77, "R7");
    cyc(1, 1, 0, 1, 3'd1, 8'h00, 16'h0000, "R7");

    // R6: even write then odd write forms the word
    cyc(1, 0, 1, 0, 3'd4, 8'h81, 16'h0000, "R5");
    cyc(1, 0, 1, 1, 3'd4, 8'h7E, 16'h0000, "R6");
    // R7: odd write, deselected write and even read keep the write holder
    cyc(0, 0, 1, 0, 3'd4, 8'h99, 16'h0000, "R7");
    cyc(1, 1, 0, 0, 3'd4, 8'h99, 16'hABCD, "R7");
    cyc(1, 0, 1, 1, 3'd4, 8'h42, 16'h0000, "R7");

    // R10: read and write together is no access
    cyc(1, 1, 1, 0, 3'd5, 8'h11, 16'h2222, "R10");
    cyc(1, 1, 1, 1, 3'd5, 8'h33, 16'h4444, "R10");
    cyc(1, 1, 0, 1, 3'd5, 8'h00, 16'h0000, "R10");
    cyc(1, 0, 1, 1, 3'd5, 8'h55, 16'h0000, "R10");

    // random traffic, tags chosen per cycle (R2 R4 R5 R6 R8 R9 R10 R11)
    for (int i = 0; i < 2000; i++) begin
      bit c, r, w, a;
      int k;
      c = ($urandom % 4) != 0;
      k = $urandom % 8;
      r = (k == 1) || (k == 2) || (k == 3) || (k == 7);
      w = (k == 4) || (k == 5) || (k == 6) || (k == 7);
      a = $urandom % 2;
      cyc(c, r, w, a, AW'($urandom), BW'($urandom), 16'($urandom), "");
    end

    cyc(0, 0, 0, 0, 3'd0, 8'h00, 16'h0000, "R9");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule